// File: doc/BRIEF.md
# Synthesizer power-down sequencing controller

This block decides when a frequency-synthesizer core is powered down and drives the flags that follow from that decision. It takes a chip-enable pin, the 24-bit control words that the serial input register presents, and a pulse marking each charge-pump event. It outputs a power-down flag, a hold that forces the R, N and timeout counters into their load state, a charge-pump three-state enable, a lock-detect reset, and a counter-reset level.

Only words whose two low control bits select the function latch update the stored fields. Three fields are kept: the primary power-down bit, the mode bit and the counter-reset bit. There are three ways into power-down. A low chip-enable takes effect at once. The immediate programmed mode takes effect on the clock edge that latches the word. The gated programmed mode is armed by the write and takes effect only on the next charge-pump event. Word capture continues while the core is powered down.

Top module: `synth_pwr_seq`

## Requirements
- R1: While reset is held, and right after it is released with chip-enable high and no writes, every output is 0.
- R2: While chip-enable is low, `pwr_down`, `ctr_load`, `cp_tristate` and `ld_reset` are 1 in the same cycle, whatever the stored power-down bits hold.
- R3: When chip-enable returns high, the power-down outputs stay at 1 until the next rising clock edge. After that edge they fall unless a programmed power-down is in force.
- R4: A write changes the stored fields only if `wr_word[1:0]` is 2'b10. A write with any other control value has no effect on any output.
- R5: A function-latch write with bit 3 = 1 and bit 21 = 0 asserts `pwr_down` right after the edge that captures it.
- R6: A function-latch write with bit 3 = 1 and bit 21 = 1 only arms power-down. `pwr_down` rises right after the first later edge that samples `cp_event` high, and stays low until then.
- R7: A function-latch write with bit 3 = 0 ends programmed power-down at the edge that captures it. If the request was armed and not yet taken, it is cancelled, so later charge-pump events have no effect.
- R8: `ctr_load`, `cp_tristate` and `ld_reset` are each 1 exactly when `pwr_down` is 1.
- R9: `ctr_rst` equals bit 2 of the last function-latch word, independent of the power state.
- R10: Function-latch writes are captured while the core is powered down, including during a chip-enable power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip-enable pin; low forces power-down |
| wr_en | input | 1 | Strobe: `wr_word` holds a completed latch word |
| wr_word | input | 24 | Latched control word; bits [1:0] select the destination latch |
| cp_event | input | 1 | One-cycle pulse at each charge-pump event |
| pwr_down | output | 1 | Core is powered down |
| ctr_load | output | 1 | Holds R, N and timeout counters in their load state |
| cp_tristate | output | 1 | Puts the charge pump in three-state |
| ld_reset | output | 1 | Holds the digital lock detector in reset |
| ctr_rst | output | 1 | Counter reset from the stored function-latch bit |

## Verification
A stale armed request shows up as a `pwr_down` rise on a charge-pump event after the cancelling write, and that rise is visible one edge after the event. A lost or misdecoded field shows in the cycle after the write, either as a wrong `ctr_rst` or as `pwr_down` that fails to rise, or rises too early, in immediate mode. A wrong chip-enable path is visible within the same cycle, or at the first edge after chip-enable rises.

// File: rtl/synth_pwr_seq.sv
module synth_pwr_seq #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned CTRL_W   = 2,
  parameter logic [CTRL_W-1:0] FUNC_SEL = 2'b10,
  parameter int unsigned PD1_POS  = 3,
  parameter int unsigned PD2_POS  = 21,
  parameter int unsigned CRST_POS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              cp_event,
  output logic              pwr_down,
  output logic              ctr_load,
  output logic              cp_tristate,
  output logic              ld_reset,
  output logic              ctr_rst
);

  logic pd_req_q, pd_gated_q, crst_q;
  logic ce_hold_q, sync_dn_q;
  logic fl_hit, pd_req_n, pd_gated_n, crst_n;
  logic armed, async_dn, sync_dn_d;

  assign fl_hit     = wr_en && (wr_word[CTRL_W-1:0] == FUNC_SEL);
  assign pd_req_n   = fl_hit ? wr_word[PD1_POS]  : pd_req_q;
  assign pd_gated_n = fl_hit ? wr_word[PD2_POS]  : pd_gated_q;
  assign crst_n     = fl_hit ? wr_word[CRST_POS] : crst_q;

  assign armed     = pd_req_q & pd_gated_q & ~sync_dn_q;
  assign async_dn  = pd_req_q & ~pd_gated_q;
  assign sync_dn_d = pd_req_n & (sync_dn_q | (armed & cp_event));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_req_q   <= 1'b0;
      pd_gated_q <= 1'b0;
      crst_q     <= 1'b0;
      ce_hold_q  <= 1'b0;
      sync_dn_q  <= 1'b0;
    end else begin
      pd_req_q   <= pd_req_n;
      pd_gated_q <= pd_gated_n;
      crst_q     <= crst_n;
      ce_hold_q  <= ~chip_en;
      sync_dn_q  <= sync_dn_d;
    end
  end

  assign pwr_down    = ~chip_en | ce_hold_q | async_dn | sync_dn_q;
  assign ctr_load    = pwr_down;
  assign cp_tristate = pwr_down;
  assign ld_reset    = pwr_down;
  assign ctr_rst     = crst_q;

endmodule

// File: rtl/synth_pwr_seq_chk.sv
module synth_pwr_seq_chk #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned CTRL_W   = 2,
  parameter logic [CTRL_W-1:0] FUNC_SEL = 2'b10,
  parameter int unsigned PD1_POS  = 3,
  parameter int unsigned PD2_POS  = 21,
  parameter int unsigned CRST_POS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_word,
  input logic              cp_event,
  input logic              pwr_down,
  input logic              ctr_load,
  input logic              cp_tristate,
  input logic              ld_reset,
  input logic              ctr_rst
);

  logic sel;
  assign sel = wr_en && (wr_word[CTRL_W-1:0] == FUNC_SEL);

  AST_CE_LOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (pwr_down && ctr_load && cp_tristate && ld_reset)); // R2

  AST_ASYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_word[PD1_POS] && !wr_word[PD2_POS]) |=> pwr_down); // R5

  AST_NO_SPONT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && chip_en && !wr_en && !cp_event) |=> (!pwr_down || !chip_en)); // R6

  AST_CLEAR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_word[PD1_POS] && chip_en) |=> (pwr_down == !chip_en)); // R7

  AST_CRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (ctr_rst == $past(wr_word[CRST_POS]))); // R9

  AST_CRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ctr_rst)); // R4

endmodule

bind synth_pwr_seq synth_pwr_seq_chk #(
  .WORD_W(WORD_W), .CTRL_W(CTRL_W), .FUNC_SEL(FUNC_SEL),
  .PD1_POS(PD1_POS), .PD2_POS(PD2_POS), .CRST_POS(CRST_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_en(wr_en),
  .wr_word(wr_word), .cp_event(cp_event), .pwr_down(pwr_down),
  .ctr_load(ctr_load), .cp_tristate(cp_tristate), .ld_reset(ld_reset),
  .ctr_rst(ctr_rst)
);

// File: tb/sim_synth_pwr_seq.sv
module sim_synth_pwr_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b1;
  logic wr_en = 1'b0;
  logic [23:0] wr_word = '0;
  logic cp_event = 1'b0;
  logic pwr_down, ctr_load, cp_tristate, ld_reset, ctr_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  synth_pwr_seq u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_en(wr_en),
    .wr_word(wr_word), .cp_event(cp_event), .pwr_down(pwr_down),
    .ctr_load(ctr_load), .cp_tristate(cp_tristate), .ld_reset(ld_reset),
    .ctr_rst(ctr_rst)
  );

  localparam logic [23:0] FL  = 24'h000002;
  localparam logic [23:0] PDA = 24'h000008;
  localparam logic [23:0] PDB = 24'h200000;
  localparam logic [23:0] CRB = 24'h000004;

  function automatic logic [28:0] v(bit ce, bit wr, logic [23:0] w, bit ev, bit pd, bit cr);
    return {ce, wr, w, ev, pd, cr};
  endfunction

  localparam int NV = 25;
  localparam logic [28:0] VEC [NV] = '{
    v(1,1,FL,0,0,0),
    v(1,1,FL|PDA,0,1,0),                 // R5
    v(1,0,24'h0,1,1,0),
    v(1,1,FL,0,0,0),                     // R7
    v(1,1,FL|PDA|PDB,0,0,0),             // R6 armed
    v(1,0,24'h0,0,0,0),
    v(1,0,24'h0,1,1,0),                  // R6 fired
    v(1,0,24'h0,0,1,0),
    v(1,1,FL|PDB,0,0,0),                 // R7
    v(1,1,FL|PDA|PDB,0,0,0),
    v(1,1,FL|PDB,0,0,0),                 // R7 cancel
    v(1,0,24'h0,1,0,0),
    v(1,1,24'h000003|PDA,0,0,0),         // R4
    v(1,1,24'h000000|PDA|CRB,0,0,0),     // R4
    v(1,1,FL|CRB,0,0,1),                 // R9
    v(0,0,24'h0,0,1,1),                  // R2
    v(0,1,FL|PDA|PDB,0,1,0),             // R10
    v(1,0,24'h0,0,0,0),                  // R3
    v(1,0,24'h0,1,1,0),
    v(0,0,24'h0,0,1,0),
    v(1,1,FL,0,0,0),
    v(0,1,FL|PDA|PDB,1,1,0),
    v(1,0,24'h0,0,0,0),
    v(1,0,24'h0,1,1,0),
    v(1,1,FL,0,0,0)
  };

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags(string req, logic exp);
    chk({req, " pwr_down"}, pwr_down, exp);
    chk({"R8 ctr_load (", req, ")"}, ctr_load, exp);
    chk({"R8 cp_tristate (", req, ")"}, cp_tristate, exp);
    chk({"R8 ld_reset (", req, ")"}, ld_reset, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk_flags("R1 in reset", 1'b0);
    chk("R1 ctr_rst in reset", ctr_rst, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk_flags("R1 after reset", 1'b0);
    chk("R1 ctr_rst after reset", ctr_rst, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chip_en  = VEC[i][28];
      wr_en    = VEC[i][27];
      wr_word  = VEC[i][26:3];
      cp_event = VEC[i][2];
      @(posedge clk);
      #2;
      chk_flags($sformatf("R2-R7 vector %0d", i), VEC[i][1]);
      chk($sformatf("R9/R10 ctr_rst vector %0d", i), ctr_rst, VEC[i][0]);
    end

    @(negedge clk);
    wr_en = 1'b0; cp_event = 1'b0; chip_en = 1'b0;
    #1;
    chk_flags("R2 immediate on chip_en low", 1'b1);
    @(negedge clk);
    chip_en = 1'b1;
    #1;
    chk_flags("R3 held until edge", 1'b1);
    @(posedge clk);
    #2;
    chk_flags("R3 released after edge", 1'b0);

    @(negedge clk);
    wr_en = 1'b1; wr_word = FL | PDA | CRB;
    #1;
    chk_flags("R5 not before capture edge", 1'b0);
    @(posedge clk);
    #2;
    chk_flags("R5 after capture edge", 1'b1);
    chk("R9 ctr_rst set", ctr_rst, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    chk_flags("R1 mid-run reset", 1'b0);
    chk("R1 ctr_rst mid-run reset", ctr_rst, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule